// File: doc/BRIEF.md
# Striped XOR-Parity Memory Datapath

This block connects a cache-line request port to five memory lanes. Lanes 0 to 3 carry data and lane 4 carries parity. A write takes a whole line and cuts it into four equal blocks, one for each data lane. In the same cycle the parity lane receives the XOR of those four blocks. The lowest bit of the line address selects one of two interleaved channels. Every lane write is issued at once, and the block never fetches old parity, because a write always covers the whole line.

A read returns all five lane blocks together with one ECC-bad flag per lane. ECC itself is computed elsewhere. The block rebuilds a flagged data block from the other four lanes. It also compares lines that ECC passed against their parity, and raises a non-maskable error when the two disagree. One lane can be marked offline. The block then writes and reads with the remaining four lanes, and ECC alone protects the data. A counter records how many reads were repaired.

Top module: `stripe_parity_dp`

## Requirements
- R1: One cycle after `wr_valid`, lane i (0 to 3) carries `wr_line[64*i+63:64*i]`, and all online lane enables are high together for exactly that cycle.
- R2: In that same cycle, lane 4 carries the bitwise XOR of the four data blocks.
- R3: `lane_wr_chan` equals bit 0 of the line address (0 for even, 1 for odd). `lane_wr_addr` is the line address shifted right by one.
- R4: A write never waits on, and is never altered by, a read that is in progress or that starts in the same cycle.
- R5: No lane is offline and ECC flags exactly one data lane. The returned line then has that block replaced by the XOR of the other three data blocks and the parity block. If only the parity lane is flagged, the data is returned unchanged.
- R6: No lane is offline and no lane is flagged, but the XOR of all five lanes is non-zero. The block then pulses `err_nmi` and holds `rsp_valid` low for that line. Exactly one of `rsp_valid`, `err_nmi` and `err_uncorr` answers each read.
- R7: A read presented with `rd_valid` gets its answer exactly 2 cycles later. This holds whether the line was clean or repaired.
- R8: `offline_en` with `offline_lane` in 0..4 takes that lane offline, and values 5..7 take no lane offline. The offline lane's write enable stays low and its ECC flag is ignored. If the offline lane is a data lane, a read rebuilds its block from the other four lanes. An ECC flag on any online lane gives `err_uncorr`, and no parity cross-check is made.
- R9: `corr_count` increments by one for each read in which an ECC-flagged data block was replaced. It does not increment for parity-only flags or for offline rebuilds.
- R10: No lane is offline and ECC flags two or more lanes. The block then pulses `err_uncorr` and returns no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Cache-line address of the write |
| wr_line | input | 4*BLK_W | Write line data |
| offline_en | input | 1 | Enables degraded mode |
| offline_lane | input | 3 | Index of the offline lane (0-4) |
| rd_valid | input | 1 | All five lane responses are present |
| rd_lanes | input | 5*BLK_W | Read blocks, lane i at bits [BLK_W*i +: BLK_W] |
| rd_ecc_bad | input | 5 | Per-lane ECC-bad flag |
| lane_wr_en | output | 5 | Per-lane write enable |
| lane_wr_data | output | 5*BLK_W | Per-lane write blocks, parity in lane 4 |
| lane_wr_addr | output | ADDR_W-1 | Address within the selected channel |
| lane_wr_chan | output | 1 | Channel select |
| rsp_valid | output | 1 | Read line valid |
| rsp_line | output | 4*BLK_W | Returned read line |
| err_nmi | output | 1 | Undetected-by-ECC mismatch pulse |
| err_uncorr | output | 1 | Uncorrectable read pulse |
| corr_count | output | CNT_W | Number of repaired reads |

## Verification
The bench uses the default parameters: 64-bit blocks, a 256-bit line, a 32-bit line address and a 16-bit counter. At these sizes random lines exercise every bit of every lane and both channel parities. Directed corruptions reach each lane in turn, parity-only faults, double faults, silent single-bit flips, and every offline lane choice.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    localparam int DATA_LANES = 4;
    localparam int ALL_LANES  = 5;
    localparam int PAR_IDX    = 4;

    typedef enum logic [1:0] {
        OUT_CLEAN    = 2'd0,
        OUT_FIXED    = 2'd1,
        OUT_MISMATCH = 2'd2,
        OUT_UNCORR   = 2'd3
    } rd_outcome_e;

    function automatic logic [ALL_LANES-1:0] lane_mask(input logic en, input logic [2:0] sel);
        logic [ALL_LANES-1:0] m;
        m = '0;
        if (en && (sel < 3'd5)) m[sel] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/stripe_wr_path.sv
module stripe_wr_path
    import stripe_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_LANES*BLK_W-1:0]   wr_line,
    input  logic [ALL_LANES-1:0]          off_mask,
    output logic [ALL_LANES-1:0]          lane_wr_en,
    output logic [ALL_LANES*BLK_W-1:0]    lane_wr_data,
    output logic [ADDR_W-2:0]             lane_wr_addr,
    output logic                          lane_wr_chan
);

    logic [BLK_W-1:0] par_blk;
    logic [BLK_W-1:0] out_syn;

    always_comb begin
        par_blk = '0;
        for (int i = 0; i < DATA_LANES; i++) par_blk ^= wr_line[i*BLK_W +: BLK_W];
    end

    generate
        for (genvar g = 0; g < DATA_LANES; g++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst)           lane_wr_data[g*BLK_W +: BLK_W] <= '0;
                else if (wr_valid) lane_wr_data[g*BLK_W +: BLK_W] <= wr_line[g*BLK_W +: BLK_W];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_wr_en <= '0;
            lane_wr_data[PAR_IDX*BLK_W +: BLK_W] <= '0;
            lane_wr_addr <= '0;
            lane_wr_chan <= 1'b0;
        end else begin
            lane_wr_en <= wr_valid ? ~off_mask : '0;
            if (wr_valid) begin
                lane_wr_data[PAR_IDX*BLK_W +: BLK_W] <= par_blk;
                lane_wr_addr <= wr_addr[ADDR_W-1:1];
                lane_wr_chan <= wr_addr[0];
            end
        end
    end

    always_comb begin
        out_syn = '0;
        for (int i = 0; i < ALL_LANES; i++) out_syn ^= lane_wr_data[i*BLK_W +: BLK_W];
    end

    AST_WR_PAR_BALANCED: assert property (@(posedge clk) disable iff (rst)
        (|lane_wr_en) |-> (out_syn == '0)); // R2
    AST_WR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        (|lane_wr_en) |-> $past(wr_valid)); // R1
    AST_WR_OFFLINE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lane_wr_en & $past(off_mask)) == '0); // R8

endmodule

// File: rtl/stripe_rd_path.sv
module stripe_rd_path
    import stripe_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_valid,
    input  logic [ALL_LANES*BLK_W-1:0]    rd_lanes,
    input  logic [ALL_LANES-1:0]          rd_ecc_bad,
    input  logic [ALL_LANES-1:0]          off_mask,
    output logic                          rsp_valid,
    output logic [DATA_LANES*BLK_W-1:0]   rsp_line,
    output logic                          err_nmi,
    output logic                          err_uncorr,
    output logic [CNT_W-1:0]              corr_count
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic                          s1_v;
    logic [ALL_LANES*BLK_W-1:0]    s1_lanes;
    logic [ALL_LANES-1:0]          s1_bad;
    logic [ALL_LANES-1:0]          s1_off;

    logic [BLK_W-1:0]              syn;
    logic [ALL_LANES-1:0]          eff_bad;
    logic [2:0]                    nbad;
    logic [DATA_LANES-1:0]         fix;
    rd_outcome_e                   outcome;
    logic [DATA_LANES*BLK_W-1:0]   line_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v     <= 1'b0;
            s1_lanes <= '0;
            s1_bad   <= '0;
            s1_off   <= '0;
        end else begin
            s1_v <= rd_valid;
            if (rd_valid) begin
                s1_lanes <= rd_lanes;
                s1_bad   <= rd_ecc_bad;
                s1_off   <= off_mask;
            end
        end
    end

    always_comb begin
        syn = '0;
        for (int i = 0; i < ALL_LANES; i++) syn ^= s1_lanes[i*BLK_W +: BLK_W];
        eff_bad = s1_bad & ~s1_off;
        nbad    = 3'($countones(eff_bad));
        fix     = '0;
        outcome = OUT_CLEAN;
        if (|s1_off) begin
            fix     = s1_off[DATA_LANES-1:0];
            outcome = (nbad != 3'd0) ? OUT_UNCORR : OUT_CLEAN;
        end else if (nbad == 3'd0) begin
            outcome = (syn != '0) ? OUT_MISMATCH : OUT_CLEAN;
        end else if (nbad == 3'd1) begin
            fix     = eff_bad[DATA_LANES-1:0];
            outcome = (|eff_bad[DATA_LANES-1:0]) ? OUT_FIXED : OUT_CLEAN;
        end else begin
            outcome = OUT_UNCORR;
        end
    end

    generate
        for (genvar g = 0; g < DATA_LANES; g++) begin : g_fix
            assign line_n[g*BLK_W +: BLK_W] = fix[g] ? (s1_lanes[g*BLK_W +: BLK_W] ^ syn)
                                                     : s1_lanes[g*BLK_W +: BLK_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_line   <= '0;
            err_nmi    <= 1'b0;
            err_uncorr <= 1'b0;
            corr_count <= '0;
        end else begin
            rsp_valid  <= s1_v && ((outcome == OUT_CLEAN) || (outcome == OUT_FIXED));
            err_nmi    <= s1_v && (outcome == OUT_MISMATCH);
            err_uncorr <= s1_v && (outcome == OUT_UNCORR);
            if (s1_v) rsp_line <= line_n;
            if (s1_v && (outcome == OUT_FIXED)) corr_count <= corr_count + CNT_ONE;
        end
    end

    AST_RD_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_valid, err_nmi, err_uncorr})); // R6
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || err_nmi || err_uncorr) |-> $past(rd_valid, 2)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (corr_count == $past(corr_count)) || (corr_count == $past(corr_count) + CNT_ONE)); // R9
    AST_CNT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        (corr_count != $past(corr_count)) |-> rsp_valid); // R9

endmodule

// File: rtl/stripe_parity_dp.sv
module stripe_parity_dp
    import stripe_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [4*BLK_W-1:0]          wr_line,
    input  logic                        offline_en,
    input  logic [2:0]                  offline_lane,
    input  logic                        rd_valid,
    input  logic [5*BLK_W-1:0]          rd_lanes,
    input  logic [4:0]                  rd_ecc_bad,
    output logic [4:0]                  lane_wr_en,
    output logic [5*BLK_W-1:0]          lane_wr_data,
    output logic [ADDR_W-2:0]           lane_wr_addr,
    output logic                        lane_wr_chan,
    output logic                        rsp_valid,
    output logic [4*BLK_W-1:0]          rsp_line,
    output logic                        err_nmi,
    output logic                        err_uncorr,
    output logic [CNT_W-1:0]            corr_count
);

    logic [ALL_LANES-1:0] off_mask;

    assign off_mask = lane_mask(offline_en, offline_lane);

    stripe_wr_path #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_line(wr_line), .off_mask(off_mask),
        .lane_wr_en(lane_wr_en), .lane_wr_data(lane_wr_data),
        .lane_wr_addr(lane_wr_addr), .lane_wr_chan(lane_wr_chan)
    );

    stripe_rd_path #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_lanes(rd_lanes), .rd_ecc_bad(rd_ecc_bad), .off_mask(off_mask),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .err_nmi(err_nmi),
        .err_uncorr(err_uncorr), .corr_count(corr_count)
    );

    AST_TOP_CHAN_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (|lane_wr_en) |-> (lane_wr_chan == $past(wr_addr[0]))); // R3

endmodule

// File: tb/stripe_parity_dp_test.sv
module stripe_parity_dp_test;

    localparam int BW = 64;
    localparam int AW = 32;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_valid = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [4*BW-1:0] wr_line = '0;
    logic            offline_en = 1'b0;
    logic [2:0]      offline_lane = 3'd7;
    logic            rd_valid = 1'b0;
    logic [5*BW-1:0] rd_lanes = '0;
    logic [4:0]      rd_ecc_bad = '0;
    logic [4:0]      lane_wr_en;
    logic [5*BW-1:0] lane_wr_data;
    logic [AW-2:0]   lane_wr_addr;
    logic            lane_wr_chan;
    logic            rsp_valid;
    logic [4*BW-1:0] rsp_line;
    logic            err_nmi;
    logic            err_uncorr;
    logic [CW-1:0]   corr_count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    stripe_parity_dp #(.BLK_W(BW), .ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_line(wr_line),
        .offline_en(offline_en), .offline_lane(offline_lane), .rd_valid(rd_valid),
        .rd_lanes(rd_lanes), .rd_ecc_bad(rd_ecc_bad), .lane_wr_en(lane_wr_en),
        .lane_wr_data(lane_wr_data), .lane_wr_addr(lane_wr_addr), .lane_wr_chan(lane_wr_chan),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .err_nmi(err_nmi),
        .err_uncorr(err_uncorr), .corr_count(corr_count)
    );

    task automatic chk(input bit ok, input string req, input logic [5*BW-1:0] act, input logic [5*BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [5*BW-1:0] make_lanes(input logic [4*BW-1:0] line);
        logic [BW-1:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) p = p ^ line[i*BW +: BW];
        return {p, line};
    endfunction

    // kind: 0 data valid, 1 data valid after ECC repair, 2 nmi, 3 uncorrectable
    function automatic void model(input logic [5*BW-1:0] ln, input logic [4:0] bad,
                                  input logic oen, input logic [2:0] osel,
                                  output int kind, output logic [4*BW-1:0] line);
        logic [4:0] m;
        logic [4:0] eff;
        logic [BW-1:0] x;
        int n;
        int tgt;
        m = '0;
        if (oen && osel < 3'd5) m[osel] = 1'b1;
        eff = bad & ~m;
        n = 0;
        tgt = -1;
        for (int i = 0; i < 5; i++) if (eff[i]) begin n++; tgt = i; end
        line = ln[4*BW-1:0];
        kind = 0;
        if (m != 0) begin
            if (n > 0) kind = 3;
            else if (osel < 3'd4) tgt = int'(osel);
            else tgt = -1;
        end else if (n >= 2) begin
            kind = 3;
        end else if (n == 1) begin
            if (tgt == 4) tgt = -1;
            else kind = 1;
        end else begin
            x = '0;
            for (int i = 0; i < 5; i++) x = x ^ ln[i*BW +: BW];
            if (x != '0) kind = 2;
        end
        if (kind < 2 && tgt >= 0) begin
            x = '0;
            for (int i = 0; i < 5; i++) if (i != tgt) x = x ^ ln[i*BW +: BW];
            line[tgt*BW +: BW] = x;
        end
    endfunction

    task automatic do_read(input logic [5*BW-1:0] ln, input logic [4:0] bad, input string req);
        int kind;
        logic [4*BW-1:0] eline;
        model(ln, bad, offline_en, offline_lane, kind, eline);
        @(negedge clk);
        rd_lanes = ln;
        rd_ecc_bad = bad;
        rd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(!rsp_valid && !err_nmi && !err_uncorr, {req, " R7 early"}, '0, '0);
        @(posedge clk);
        @(negedge clk);
        if (kind == 1) exp_cnt++;
        if (kind < 2)
            chk(rsp_valid && !err_nmi && !err_uncorr && rsp_line == eline, req, rsp_line, eline);
        else if (kind == 2)
            chk(err_nmi && !rsp_valid && !err_uncorr, {req, " R6"}, {err_nmi, rsp_valid}, 2'b10);
        else
            chk(err_uncorr && !rsp_valid && !err_nmi, {req, " R10"}, {err_uncorr, rsp_valid}, 2'b10);
        chk(corr_count == CW'(exp_cnt), {req, " R9 count"}, corr_count, exp_cnt);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [4*BW-1:0] line, input logic [4:0] exp_en);
        logic [5*BW-1:0] exp_lanes;
        exp_lanes = make_lanes(line);
        @(negedge clk);
        wr_addr = a;
        wr_line = line;
        wr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(lane_wr_data[4*BW-1:0] == line, "R1 data split", lane_wr_data, exp_lanes);
        chk(lane_wr_data[5*BW-1:4*BW] == exp_lanes[5*BW-1:4*BW], "R2 parity", lane_wr_data, exp_lanes);
        chk(lane_wr_en == exp_en, "R1/R8 enables", lane_wr_en, exp_en);
        chk(lane_wr_chan == a[0] && lane_wr_addr == a[AW-1:1], "R3 chan/addr",
            {lane_wr_chan, lane_wr_addr}, {a[0], a[AW-1:1]});
        @(posedge clk);
        @(negedge clk);
        chk(lane_wr_en == 5'b0, "R1 single cycle", lane_wr_en, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [4*BW-1:0] line;
        logic [5*BW-1:0] ln;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(lane_wr_en == 0 && !rsp_valid && !err_nmi && !err_uncorr && corr_count == 0,
            "reset R1 R9", {lane_wr_en, rsp_valid, corr_count}, '0);

        // writes: odd and even addresses, random lines
        do_write(32'h0000_0010, {4{64'hFFFF_0000_FFFF_0000}}, 5'h1f);
        do_write(32'h1234_5677, {rnd64(), rnd64(), rnd64(), rnd64()}, 5'h1f);
        for (int k = 0; k < 20; k++)
            do_write($urandom, {rnd64(), rnd64(), rnd64(), rnd64()}, 5'h1f);

        // R4: write and read in the same cycle
        line = {rnd64(), rnd64(), rnd64(), rnd64()};
        ln = make_lanes({rnd64(), rnd64(), rnd64(), rnd64()});
        @(negedge clk);
        wr_addr = 32'h0000_0033; wr_line = line; wr_valid = 1'b1;
        rd_lanes = ln; rd_ecc_bad = 5'b00010; rd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        chk(lane_wr_en == 5'h1f && lane_wr_data == make_lanes(line) && lane_wr_chan,
            "R4 concurrent write", lane_wr_data, make_lanes(line));
        @(posedge clk);
        @(negedge clk);
        exp_cnt++;
        chk(rsp_valid && rsp_line == ln[4*BW-1:0], "R4 concurrent read", rsp_line, ln[4*BW-1:0]);

        // directed reads in normal mode
        ln = make_lanes({rnd64(), rnd64(), rnd64(), rnd64()});
        do_read(ln, 5'b0, "R5 clean");
        for (int l = 0; l < 4; l++) begin
            logic [5*BW-1:0] c;
            c = ln;
            c[l*BW +: BW] = c[l*BW +: BW] ^ rnd64() ^ 64'h1;
            do_read(c, 5'(1) << l, "R5 R7 R9 repair lane");
        end
        ln[4*BW +: BW] = ~ln[4*BW +: BW];
        do_read(ln, 5'b10000, "R5 R9 parity-only flag");
        ln = make_lanes({rnd64(), rnd64(), rnd64(), rnd64()});
        ln[100] = ~ln[100];
        do_read(ln, 5'b0, "R6 silent flip");
        do_read(ln, 5'b00101, "R10 double flag");
        do_read(ln, 5'b11111, "R10 all flagged");

        // random mix
        for (int k = 0; k < 60; k++) begin
            int sc;
            int l;
            sc = int'($urandom % 5);
            l = int'($urandom % 5);
            ln = make_lanes({rnd64(), rnd64(), rnd64(), rnd64()});
            case (sc)
                1: begin ln[l*BW +: BW] = ln[l*BW +: BW] ^ 64'h8; do_read(ln, 5'(1) << l, "R5 random single"); end
                2: begin ln[$urandom % (5*BW)] ^= 1'b1; do_read(ln, 5'b0, "R6 random silent"); end
                3: do_read(ln, 5'(1) << l | 5'(1) << ((l + 1) % 5), "R10 random double");
                default: do_read(ln, 5'b0, "R5 random clean");
            endcase
        end

        // degraded mode, each lane offline
        for (int o = 0; o < 5; o++) begin
            @(negedge clk);
            offline_en = 1'b1;
            offline_lane = 3'(o);
            line = {rnd64(), rnd64(), rnd64(), rnd64()};
            do_write($urandom, line, 5'h1f & ~(5'(1) << o));
            ln = make_lanes(line);
            ln[o*BW +: BW] = rnd64();
            do_read(ln, 5'(1) << o, "R8 offline rebuild");
            ln = make_lanes(line);
            do_read(ln, 5'(1) << ((o + 1) % 5), "R8 offline online-flag");
        end
        @(negedge clk);
        offline_lane = 3'd6;
        ln = make_lanes({rnd64(), rnd64(), rnd64(), rnd64()});
        ln[7] = ~ln[7];
        do_read(ln, 5'b0, "R8 R6 out-of-range lane keeps check");
        offline_en = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule